// File: doc/BRIEF.md
# Clock-Stop Detecting Reset Controller

This block holds one byte-wide reset configuration register on a simple synchronous bus: address, write strobe, write data and registered read data. It runs on a free-running RC reference clock. From that clock it watches two external clocks, a fast main clock and a slow sub clock. Each watched clock drives a toggle flop in its own domain, and that toggle crosses into the RC domain through a synchronizer chain. An RC-domain counter measures how long the synchronized toggle has stayed still. When the count reaches a selectable threshold, the block latches a stop flag for that clock.

The block raises a one-cycle reset request in three cases:
- software writes a 1 to the trigger bit;
- a stop flag is set while clock-stop reset is enabled;
- an external low-voltage reset input is asserted while low-voltage reset is enabled.

The block also drives two enable outputs toward an external low-voltage detector. It does not sequence the chip's reset, and it does not model the RC oscillator or the detector.

Top module: `clkstop_rst_ctrl`

## Requirements
- R1: During and after reset, the register at `REG_ADDR` (default 0) reads 0x06. `lvd_en_o` and `lvr_en_o` are 1, and both stop flags are 0.
- R2: Register bits 5:1 are writable. Their layout is: bit1 low-voltage reset enable, bit2 detector enable, bit3 clock-stop reset enable, bit4 main fast window, bit5 sub fast window. Read data is registered and appears one cycle after the address is presented. Bits 7:6 and bit 0 always read 0, and writes to bits 7:6 are ignored.
- R3: A write with bit 0 = 1 drives `rst_req_o` high in the cycle that follows the write edge. A write with bit 0 = 0 produces no request.
- R4: `lvd_en_o` follows register bit 2 and `lvr_en_o` follows register bit 1, from the cycle after the write.
- R5: The main clock is flagged stopped after its threshold of idle RC cycles: 8 when bit 4 = 0, 4 when bit 4 = 1. `mclk_stop_o` rises 1 to 6 RC cycles after that threshold, counted from the last main edge.
- R6: The sub clock is flagged stopped after its threshold of idle RC cycles: 512 when bit 5 = 0, 32 when bit 5 = 1. `sclk_stop_o` rises within the threshold minus 2 to the threshold plus 6 RC cycles after gating.
- R7: A watched clock that keeps running is never flagged stopped.
- R8: Once a stop flag is set, it stays set even if the clock resumes, until the next reset.
- R9: A stop flag produces exactly one `rst_req_o` pulse when bit 3 = 1. It produces none when bit 3 = 0.
- R10: A rising `lvr_in` produces exactly one `rst_req_o` pulse when bit 1 = 1. It produces none when bit 1 = 0.
- R11: Writes and reads at any address other than `REG_ADDR` have no effect on the register and read 0.
- R12: `rst_req_o` is one cycle wide for each software trigger or each rising enabled cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rc | input | 1 | Free-running RC reference clock; the bus and all detection logic run on it |
| rst | input | 1 | Synchronous active-high reset |
| main_clk | input | 1 | Watched main clock |
| sub_clk | input | 1 | Watched sub clock |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lvr_in | input | 1 | Asynchronous low-voltage reset indication from the external detector |
| lvd_en_o | output | 1 | Low-voltage detector enable |
| lvr_en_o | output | 1 | Low-voltage reset enable |
| mclk_stop_o | output | 1 | Latched main-clock stop flag |
| sclk_stop_o | output | 1 | Latched sub-clock stop flag |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
A corrupted configuration bit appears at the ports one cycle later, either in read data or on an enable output. The full sweep of all 256 write values therefore exposes it within two cycles of the write. A wrong threshold or a faulty counter shifts the cycle in which a stop flag rises. The bench measures that cycle from the moment it gates a clock, so a threshold error surfaces within about 520 RC cycles in the worst case. A stop flag that fails to stay latched, or request pulses that are missing, extra or too wide, all show up in the same run. The bench sees them through pulse counts on `rst_req_o` and through the flag outputs after the clock resumes.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Register bit positions (the bus decodes and the bench rely on them)
  localparam int unsigned BIT_SWTRIG   = 0;
  localparam int unsigned BIT_LVRST_EN = 1;
  localparam int unsigned BIT_LVDET_EN = 2;
  localparam int unsigned BIT_STOP_EN  = 3;
  localparam int unsigned BIT_MAIN_FST = 4;
  localparam int unsigned BIT_SUB_FST  = 5;

  localparam logic [7:0] CFG_RST_VAL = 8'h06;
  localparam logic [7:0] CFG_WR_MASK = 8'h3E;

  typedef struct packed {
    logic sub_fast;
    logic main_fast;
    logic stop_rst_en;
    logic lv_det_en;
    logic lv_rst_en;
  } cfg_t;

  function automatic cfg_t cfg_from_byte(input logic [7:0] b);
    cfg_t c;
    c.sub_fast    = b[BIT_SUB_FST];
    c.main_fast   = b[BIT_MAIN_FST];
    c.stop_rst_en = b[BIT_STOP_EN];
    c.lv_det_en   = b[BIT_LVDET_EN];
    c.lv_rst_en   = b[BIT_LVRST_EN];
    return c;
  endfunction

endpackage

// File: rtl/cfg_reg.sv
module cfg_reg
  import clkstop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output cfg_t              cfg,
  output logic              sw_trig
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

  logic [7:0] store_q;
  logic       hit;

  assign hit = (bus_addr == SEL_ADDR);

  // Only writable bits are stored; the trigger bit and bits 7:6 never hold state
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= CFG_RST_VAL;
    end else if (bus_we && hit) begin
      store_q <= bus_wdata & CFG_WR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else begin
      bus_rdata <= hit ? (store_q & CFG_WR_MASK) : 8'h00;
    end
  end

  assign cfg     = cfg_from_byte(store_q);
  assign sw_trig = bus_we && hit && bus_wdata[BIT_SWTRIG];

endmodule

// File: rtl/toggle_src.sv
module toggle_src (
  input  logic clk_w,
  input  logic rst,
  output logic tog
);

  // Runs in the watched clock domain; each edge flips the level seen by the RC side
  always_ff @(posedge clk_w) begin
    if (rst) tog <= 1'b0;
    else     tog <= ~tog;
  end

endmodule

// File: rtl/stop_mon.sv
module stop_mon #(
  parameter int unsigned LONG_THR  = 8,
  parameter int unsigned SHORT_THR = 4,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  input  logic fast_sel,
  output logic stopped
);

  localparam int unsigned CNT_W = $clog2(LONG_THR + 1);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_THR);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_THR);

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic              moved;
  logic [CNT_W-1:0]  idle_q;
  logic [CNT_W-1:0]  limit;

  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= tog_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-2:0], tog_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_N-1];
  end

  assign moved = sync_q[SYNC_N-1] ^ last_q;
  assign limit = fast_sel ? SHORT_V : LONG_V;

  // Idle counter: cleared by activity, saturates at the selected limit
  always_ff @(posedge clk) begin
    if (rst)                idle_q <= '0;
    else if (moved)         idle_q <= '0;
    else if (idle_q < limit) idle_q <= idle_q + 1'b1;
  end

  // Sticky stop flag
  always_ff @(posedge clk) begin
    if (rst)                  stopped <= 1'b0;
    else if (idle_q >= limit) stopped <= 1'b1;
  end

endmodule

// File: rtl/req_gen.sv
module req_gen #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_trig,
  input  logic stop_rst_en,
  input  logic lv_rst_en,
  input  logic main_stop,
  input  logic sub_stop,
  input  logic lvr_in,
  output logic rst_req
);

  logic [SYNC_N-1:0] lvr_sync_q;
  logic              cause;
  logic              cause_q;

  generate
    if (SYNC_N == 1) begin : g_lvr1
      always_ff @(posedge clk) begin
        if (rst) lvr_sync_q <= '0;
        else     lvr_sync_q <= lvr_in;
      end
    end else begin : g_lvrn
      always_ff @(posedge clk) begin
        if (rst) lvr_sync_q <= '0;
        else     lvr_sync_q <= {lvr_sync_q[SYNC_N-2:0], lvr_in};
      end
    end
  endgenerate

  assign cause = (stop_rst_en && (main_stop || sub_stop)) ||
                 (lv_rst_en && lvr_sync_q[SYNC_N-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cause_q <= cause;
      rst_req <= sw_trig || (cause && !cause_q);
    end
  end

endmodule

// File: rtl/clkstop_rst_ctrl.sv
module clkstop_rst_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_ADDR   = 0,
  parameter int unsigned MAIN_LONG  = 8,
  parameter int unsigned MAIN_SHORT = 4,
  parameter int unsigned SUB_LONG   = 512,
  parameter int unsigned SUB_SHORT  = 32,
  parameter int unsigned SYNC_N     = 2
) (
  input  logic              clk_rc,
  input  logic              rst,
  input  logic              main_clk,
  input  logic              sub_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              lvr_in,
  output logic              lvd_en_o,
  output logic              lvr_en_o,
  output logic              mclk_stop_o,
  output logic              sclk_stop_o,
  output logic              rst_req_o
);

  localparam int unsigned N_WATCH = 2;

  cfg_t              cfg;
  logic              sw_trig;
  logic [N_WATCH-1:0] wclk;
  logic [N_WATCH-1:0] wtog;
  logic [N_WATCH-1:0] wfast;
  logic [N_WATCH-1:0] wstop;

  cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk       (clk_rc),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .sw_trig   (sw_trig)
  );

  assign wclk  = {sub_clk, main_clk};
  assign wfast = {cfg.sub_fast, cfg.main_fast};

  // Index 0 watches the main clock, index 1 the sub clock
  generate
    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
      localparam int unsigned G_LONG  = (g == 0) ? MAIN_LONG  : SUB_LONG;
      localparam int unsigned G_SHORT = (g == 0) ? MAIN_SHORT : SUB_SHORT;

      toggle_src u_tog (
        .clk_w (wclk[g]),
        .rst   (rst),
        .tog   (wtog[g])
      );

      stop_mon #(.LONG_THR(G_LONG), .SHORT_THR(G_SHORT), .SYNC_N(SYNC_N)) u_mon (
        .clk      (clk_rc),
        .rst      (rst),
        .tog_in   (wtog[g]),
        .fast_sel (wfast[g]),
        .stopped  (wstop[g])
      );
    end
  endgenerate

  req_gen #(.SYNC_N(SYNC_N)) u_req (
    .clk         (clk_rc),
    .rst         (rst),
    .sw_trig     (sw_trig),
    .stop_rst_en (cfg.stop_rst_en),
    .lv_rst_en   (cfg.lv_rst_en),
    .main_stop   (wstop[0]),
    .sub_stop    (wstop[1]),
    .lvr_in      (lvr_in),
    .rst_req     (rst_req_o)
  );

  assign lvd_en_o    = cfg.lv_det_en;
  assign lvr_en_o    = cfg.lv_rst_en;
  assign mclk_stop_o = wstop[0];
  assign sclk_stop_o = wstop[1];

endmodule

// File: rtl/clkstop_rst_ctrl_chk.sv
module clkstop_rst_ctrl_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input logic              clk_rc,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              lvd_en_o,
  input logic              lvr_en_o,
  input logic              mclk_stop_o,
  input logic              sclk_stop_o,
  input logic              rst_req_o
);

  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

  // R2
  rsvd_read_zero_chk: assert property (@(posedge clk_rc) disable iff (rst)
    (bus_rdata[7:6] == 2'b00) && !bus_rdata[0]);

  // R4
  lvd_follow_chk: assert property (@(posedge clk_rc) disable iff (rst)
    (bus_we && bus_addr == SEL) |=> (lvd_en_o == $past(bus_wdata[2])) && (lvr_en_o == $past(bus_wdata[1])));

  // R8
  main_stop_sticky_chk: assert property (@(posedge clk_rc) disable iff (rst)
    mclk_stop_o |=> mclk_stop_o);

  // R8
  sub_stop_sticky_chk: assert property (@(posedge clk_rc) disable iff (rst)
    sclk_stop_o |=> sclk_stop_o);

  // R12
  req_has_cause_chk: assert property (@(posedge clk_rc) disable iff (rst)
    (rst_req_o && !$past(bus_we)) |-> (mclk_stop_o || sclk_stop_o || lvr_en_o));

  // R1
  reset_value_chk: assert property (@(posedge clk_rc)
    $fell(rst) |-> (lvd_en_o && lvr_en_o && !mclk_stop_o && !sclk_stop_o));

endmodule

bind clkstop_rst_ctrl clkstop_rst_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_rc      (clk_rc),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .lvd_en_o    (lvd_en_o),
  .lvr_en_o    (lvr_en_o),
  .mclk_stop_o (mclk_stop_o),
  .sclk_stop_o (sclk_stop_o),
  .rst_req_o   (rst_req_o)
);

// File: tb/clkstop_rst_ctrl_tb.sv
module clkstop_rst_ctrl_tb;

  localparam int RC_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic       clk_rc = 1'b0;
  logic       rst = 1'b1;
  logic       mfree = 1'b0;
  logic       sfree = 1'b0;
  logic       run_m = 1'b1;
  logic       run_s = 1'b1;
  logic       main_clk;
  logic       sub_clk;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lvr_in = 1'b0;
  logic       lvd_en_o, lvr_en_o, mclk_stop_o, sclk_stop_o, rst_req_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(RC_PERIOD/2) clk_rc = ~clk_rc;
  always #7  mfree = ~mfree;
  always #30 sfree = ~sfree;
  assign main_clk = mfree & run_m;
  assign sub_clk  = sfree & run_s;

  clkstop_rst_ctrl u_dut (
    .clk_rc(clk_rc), .rst(rst), .main_clk(main_clk), .sub_clk(sub_clk),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvr_in(lvr_in), .lvd_en_o(lvd_en_o), .lvr_en_o(lvr_en_o),
    .mclk_stop_o(mclk_stop_o), .sclk_stop_o(sclk_stop_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    run_m = 1'b1; run_s = 1'b1; lvr_in = 1'b0; bus_we = 1'b0;
    @(negedge clk_rc); rst = 1'b1;
    repeat (12) @(negedge clk_rc);
    rst = 1'b0;
  endtask

  // After return, sampled at the negedge that follows the write edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_rc); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk_rc); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_rc); bus_addr = a;
    @(negedge clk_rc); d = bus_rdata;
  endtask

  // Gate a watched clock, count RC cycles until its flag rises and request pulses seen
  task automatic measure(input bit is_main, output int cyc, output int pulses);
    cyc = 0; pulses = 0;
    @(negedge clk_rc);
    if (is_main) run_m = 1'b0; else run_s = 1'b0;
    while (cyc < 2000 && !(is_main ? mclk_stop_o : sclk_stop_o)) begin
      @(negedge clk_rc);
      cyc++;
      if (rst_req_o) pulses++;
    end
    repeat (4) begin
      @(negedge clk_rc);
      if (rst_req_o) pulses++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk_rc);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    int cyc, pul;

    do_reset();
    // R1 reset state
    rd(4'd0, rv);
    chk("R1 reset read", rv, 8'h06);
    chk("R1 lvd_en", lvd_en_o, 1);
    chk("R1 lvr_en", lvr_en_o, 1);
    chk("R1 main flag", mclk_stop_o, 0);
    chk("R1 sub flag", sclk_stop_o, 0);

    // R2/R3/R4/R12 sweep over every write value (clocks running, lvr_in low)
    for (int v = 0; v < 256; v++) begin
      wr(4'd0, 8'(v));
      chk("R3 trigger pulse", rst_req_o, v & 1);
      chk("R4 lvd_en", lvd_en_o, (v >> 2) & 1);
      chk("R4 lvr_en", lvr_en_o, (v >> 1) & 1);
      @(negedge clk_rc);
      chk("R12 pulse width", rst_req_o, 0);
      rd(4'd0, rv);
      chk("R2 readback", rv, v & 8'h3E);
    end

    // R11 other addresses
    wr(4'd0, 8'h16);
    wr(4'd5, 8'h3F);
    chk("R11 no trigger off-address", rst_req_o, 0);
    rd(4'd0, rv);
    chk("R11 register untouched", rv, 8'h16);
    rd(4'd5, rv);
    chk("R11 off-address read", rv, 0);

    // R7 running clocks never flag
    wr(4'd0, 8'h38);
    repeat (700) @(negedge clk_rc);
    chk("R7 main running", mclk_stop_o, 0);
    chk("R7 sub running", sclk_stop_o, 0);

    // R5 main long window, enable off: R9 no pulse
    do_reset();
    wr(4'd0, 8'h00);
    measure(1'b1, cyc, pul);
    chk_rng("R5 main long", cyc, 9, 14);
    chk("R9 no pulse when disabled", pul, 0);
    // R8 sticky after resume
    run_m = 1'b1;
    repeat (30) @(negedge clk_rc);
    chk("R8 main flag sticky", mclk_stop_o, 1);
    do_reset();
    chk("R8 cleared by reset", mclk_stop_o, 0);

    // R5 main short window, enable on: R9 one pulse
    wr(4'd0, 8'h18);
    measure(1'b1, cyc, pul);
    chk_rng("R5 main short", cyc, 5, 10);
    chk("R9 one pulse when enabled", pul, 1);

    // R6 sub short window
    do_reset();
    wr(4'd0, 8'h28);
    measure(1'b0, cyc, pul);
    chk_rng("R6 sub short", cyc, 30, 38);
    chk("R9 one pulse sub", pul, 1);
    chk("R7 main still clear", mclk_stop_o, 0);

    // R6 sub long window
    do_reset();
    wr(4'd0, 8'h00);
    measure(1'b0, cyc, pul);
    chk_rng("R6 sub long", cyc, 510, 518);
    run_s = 1'b1;
    repeat (30) @(negedge clk_rc);
    chk("R8 sub flag sticky", sclk_stop_o, 1);

    // R10 low-voltage reset input, disabled then enabled
    do_reset();
    wr(4'd0, 8'h04);
    pul = 0;
    @(negedge clk_rc); lvr_in = 1'b1;
    repeat (8) begin @(negedge clk_rc); if (rst_req_o) pul++; end
    chk("R10 ignored when disabled", pul, 0);
    lvr_in = 1'b0;
    repeat (4) @(negedge clk_rc);
    wr(4'd0, 8'h06);
    pul = 0;
    @(negedge clk_rc); lvr_in = 1'b1;
    repeat (8) begin @(negedge clk_rc); if (rst_req_o) pul++; end
    chk("R10 one pulse when enabled", pul, 1);
    lvr_in = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule